// File: doc/BRIEF.md
# FIFO Threshold Flag Unit for a Dual-Channel UART

This block decides, for each of the two channels of a UART, when the receive FIFO holds enough characters and when the transmit FIFO has enough free room to ask for service. The interrupt and DMA logic uses these two decisions. Each channel keeps an 8-bit threshold register. Its upper nibble sets the receive level and its lower nibble sets the transmit level, in steps of `STEP` entries. A nibble of zero hands that direction back to a two-bit coarse code taken from the FIFO control register.

The FIFOs report their fill counts to the block every cycle. The block compares each count against the effective level and registers the results as ready flags. A shared read port returns a one-byte summary of all four flags at address 7 when the read is enabled for it. Otherwise the port passes through the selected channel's ordinary register value. A threshold write takes effect only when both of that channel's gating enables are set.

Top module: `uart_fifo_thresh`

## Requirements
- R1: After reset both threshold registers are zero, all four ready flags are 0, and a status read returns 8'h00.
- R2: A threshold write on a channel loads `thr_wdata` only when that channel's `thr_wr`, `efr_enh` and `mcr_thr_en` bits are all 1. Otherwise the stored value is kept.
- R3: A nonzero upper nibble N sets the receive level to 4*N. A nonzero lower nibble M sets the transmit level to 4*M. In both cases the coarse code for that direction is ignored.
- R4: When the upper nibble is zero, the receive level comes from the coarse code (2 bits per channel, channel A in bits 1:0): 0→8, 1→16, 2→56, 3→60.
- R5: When the lower nibble is zero, the transmit level comes from the coarse code: 0→8, 1→16, 2→32, 3→56.
- R6: `rx_rdy[c]` becomes 1 on the clock edge after the receive fill count is at or above the receive level, and 0 otherwise. The comparison uses the threshold value held before that edge.
- R7: `tx_rdy[c]` becomes 1 on the clock edge after the free space (DEPTH minus transmit fill) is at or above the transmit level, and 0 otherwise.
- R8: The status byte is {2'b00, rx_rdy[1], rx_rdy[0], 2'b00, tx_rdy[1], tx_rdy[0]}.
- R9: The read port behaves as follows:
  - A chip select is active low. Channel A (`cs_n[0]`) has priority over channel B.
  - `rd_data` shows the status byte when a channel is selected, `rd_addr` is 3'b111, and that channel has `mcr_rdy_en` 1 and `loopback` 0.
  - Otherwise, with a channel selected, `rd_data` shows that channel's ordinary register (`ord_a` or `ord_b`).
  - With no channel selected, `rd_data` is 8'h00.
- R10: The two channels are independent. A write, fill count or coarse code on one channel never changes the other channel's flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr | input | 2 | Threshold write strobe per channel |
| thr_wdata | input | 8 | Threshold write data (rx nibble 7:4, tx nibble 3:0) |
| efr_enh | input | 2 | Enhanced-feature enable per channel (write gate) |
| mcr_thr_en | input | 2 | Modem-control threshold-access enable per channel (write gate) |
| fcr_rx_sel | input | 4 | Coarse receive code, 2 bits per channel |
| fcr_tx_sel | input | 4 | Coarse transmit code, 2 bits per channel |
| rx_fill | input | 2*CW | Receive FIFO fill count per channel |
| tx_fill | input | 2*CW | Transmit FIFO fill count per channel |
| cs_n | input | 2 | Active-low channel selects |
| rd_addr | input | 3 | Read register address |
| mcr_rdy_en | input | 2 | Status-read enable per channel |
| loopback | input | 2 | Loopback mode per channel |
| ord_a | input | 8 | Channel A ordinary register at the read address |
| ord_b | input | 8 | Channel B ordinary register at the read address |
| rx_rdy | output | 2 | Registered receive-ready flags |
| tx_rdy | output | 2 | Registered transmit-ready flags |
| rd_data | output | 8 | Read data |

## Verification
The bench builds the block with its defaults, DEPTH 64 and STEP 4, so CW is 7. The 7-bit fill counts therefore cover every value from empty to completely full. Both ends of each comparison can be reached: a full receive FIFO clears the largest level (60), and an empty transmit FIFO clears every transmit level. With STEP 4, each nibble boundary (4*N-1 against 4*N) and each coarse level lands on an exact fill value. This lets the directed cases test the at-or-above edge precisely, while random fills and codes cover the fine/coarse override under every enable combination.

// File: rtl/uart_fifo_thresh.sv
module uart_fifo_thresh #(
  parameter int DEPTH = 64,
  parameter int STEP  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    thr_wr,
  input  logic [7:0]    thr_wdata,
  input  logic [1:0]    efr_enh,
  input  logic [1:0]    mcr_thr_en,
  input  logic [3:0]    fcr_rx_sel,
  input  logic [3:0]    fcr_tx_sel,
  input  logic [2*CW-1:0] rx_fill,
  input  logic [2*CW-1:0] tx_fill,
  input  logic [1:0]    cs_n,
  input  logic [2:0]    rd_addr,
  input  logic [1:0]    mcr_rdy_en,
  input  logic [1:0]    loopback,
  input  logic [7:0]    ord_a,
  input  logic [7:0]    ord_b,
  output logic [1:0]    rx_rdy,
  output logic [1:0]    tx_rdy,
  output logic [7:0]    rd_data
);

  function automatic logic [CW-1:0] rx_coarse(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(8);
      2'd1:    return CW'(16);
      2'd2:    return CW'(56);
      default: return CW'(60);
    endcase
  endfunction

  function automatic logic [CW-1:0] tx_coarse(input logic [1:0] code);
    case (code)
      2'd0:    return CW'(8);
      2'd1:    return CW'(16);
      2'd2:    return CW'(32);
      default: return CW'(56);
    endcase
  endfunction

  logic [15:0] thr_q;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [3:0]    rx_nib, tx_nib;
    logic [CW-1:0] rx_lvl, tx_lvl, rx_cnt, tx_free;

    assign rx_nib  = thr_q[c*8+4 +: 4];
    assign tx_nib  = thr_q[c*8   +: 4];
    assign rx_lvl  = (rx_nib != 4'd0) ? CW'(STEP) * CW'(rx_nib) : rx_coarse(fcr_rx_sel[c*2 +: 2]);
    assign tx_lvl  = (tx_nib != 4'd0) ? CW'(STEP) * CW'(tx_nib) : tx_coarse(fcr_tx_sel[c*2 +: 2]);
    assign rx_cnt  = rx_fill[c*CW +: CW];
    assign tx_free = CW'(DEPTH) - tx_fill[c*CW +: CW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q[c*8 +: 8] <= 8'h00;
        rx_rdy[c]       <= 1'b0;
        tx_rdy[c]       <= 1'b0;
      end else begin
        if (thr_wr[c] && efr_enh[c] && mcr_thr_en[c])
          thr_q[c*8 +: 8] <= thr_wdata;
        rx_rdy[c] <= rx_cnt >= rx_lvl;
        tx_rdy[c] <= tx_free >= tx_lvl;
      end
    end
  end

  logic       any_sel, sel_b, show_sts;
  logic [7:0] status;

  assign any_sel  = ~&cs_n;
  assign sel_b    = cs_n[0];
  assign show_sts = any_sel && rd_addr == 3'b111 && mcr_rdy_en[sel_b] && !loopback[sel_b];
  assign status   = {2'b00, rx_rdy, 2'b00, tx_rdy};
  assign rd_data  = !any_sel ? 8'h00 : show_sts ? status : (sel_b ? ord_b : ord_a);

endmodule

// File: rtl/uart_fifo_thresh_chk.sv
module uart_fifo_thresh_chk #(
  parameter int DEPTH = 64,
  parameter int STEP  = 4,
  parameter int CW    = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      thr_wr,
  input logic [7:0]      thr_wdata,
  input logic [1:0]      efr_enh,
  input logic [1:0]      mcr_thr_en,
  input logic [2*CW-1:0] rx_fill,
  input logic [2*CW-1:0] tx_fill,
  input logic [1:0]      cs_n,
  input logic [2:0]      rd_addr,
  input logic [1:0]      mcr_rdy_en,
  input logic [1:0]      loopback,
  input logic [1:0]      rx_rdy,
  input logic [1:0]      tx_rdy,
  input logic [7:0]      rd_data,
  input logic [15:0]     thr_q
);

  AST_THR_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !(thr_wr[0] && efr_enh[0] && mcr_thr_en[0]) |=> thr_q[7:0] == $past(thr_q[7:0])); // R2
  AST_THR_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    !(thr_wr[1] && efr_enh[1] && mcr_thr_en[1]) |=> thr_q[15:8] == $past(thr_q[15:8])); // R2
  AST_THR_LOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr[0] && efr_enh[0] && mcr_thr_en[0]) |=> thr_q[7:0] == $past(thr_wdata)); // R2
  AST_RX_LOW_A: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fill[CW-1:0] < CW'(STEP) |=> !rx_rdy[0]); // R6
  AST_RX_FULL_A: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fill[CW-1:0] == CW'(DEPTH) |=> rx_rdy[0]); // R6
  AST_TX_EMPTY_B: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fill[2*CW-1:CW] == '0 |=> tx_rdy[1]); // R7
  AST_TX_FULL_B: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fill[2*CW-1:CW] == CW'(DEPTH) |=> !tx_rdy[1]); // R7
  AST_STS_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n[0] && rd_addr == 3'b111 && mcr_rdy_en[0] && !loopback[0])
      |-> (rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00)); // R8

endmodule

bind uart_fifo_thresh uart_fifo_thresh_chk #(.DEPTH(DEPTH), .STEP(STEP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .thr_wdata(thr_wdata),
  .efr_enh(efr_enh), .mcr_thr_en(mcr_thr_en), .rx_fill(rx_fill), .tx_fill(tx_fill),
  .cs_n(cs_n), .rd_addr(rd_addr), .mcr_rdy_en(mcr_rdy_en), .loopback(loopback),
  .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .rd_data(rd_data), .thr_q(thr_q)
);

// File: tb/uart_fifo_thresh_test.sv
module uart_fifo_thresh_test;
  localparam int DEPTH = 64;
  localparam int CW = 7;

  logic clk = 0, rst_n = 0;
  logic [1:0] thr_wr = 0, efr_enh = 0, mcr_thr_en = 0, cs_n = 2'b11, mcr_rdy_en = 0, loopback = 0;
  logic [7:0] thr_wdata = 0, ord_a = 8'hA5, ord_b = 8'h5A;
  logic [3:0] fcr_rx_sel = 0, fcr_tx_sel = 0;
  logic [2:0] rd_addr = 0;
  int rxf[2] = '{0, 0};
  int txf[2] = '{0, 0};
  logic [2*CW-1:0] rx_fill, tx_fill;
  logic [1:0] rx_rdy, tx_rdy;
  logic [7:0] rd_data;

  int checks = 0, fails = 0;
  logic [7:0] mthr[2] = '{8'h00, 8'h00};
  logic [1:0] erx = 0, etx = 0;

  assign rx_fill = {CW'(rxf[1]), CW'(rxf[0])};
  assign tx_fill = {CW'(txf[1]), CW'(txf[0])};

  always #2 clk = ~clk;

  uart_fifo_thresh uut (.*);

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int rx_lvl(logic [7:0] t, logic [1:0] code);
    int tab[4] = '{8, 16, 56, 60};
    return (t[7:4] != 0) ? 4 * t[7:4] : tab[code];
  endfunction

  function automatic int tx_lvl(logic [7:0] t, logic [1:0] code);
    int tab[4] = '{8, 16, 32, 56};
    return (t[3:0] != 0) ? 4 * t[3:0] : tab[code];
  endfunction

  function automatic logic [7:0] exp_rd();
    logic b;
    if (&cs_n) return 8'h00;
    b = cs_n[0];
    if (rd_addr == 3'b111 && mcr_rdy_en[b] && !loopback[b]) return {2'b00, erx, 2'b00, etx};
    return b ? ord_b : ord_a;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(string req);
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      erx[c] = rxf[c] >= rx_lvl(mthr[c], fcr_rx_sel[c*2 +: 2]);
      etx[c] = (DEPTH - txf[c]) >= tx_lvl(mthr[c], fcr_tx_sel[c*2 +: 2]);
      if (thr_wr[c] && efr_enh[c] && mcr_thr_en[c]) mthr[c] = thr_wdata;
    end
    @(negedge clk);
    thr_wr = 0;
    chk({req, " rx"}, {6'b0, rx_rdy}, {6'b0, erx});
    chk({req, " tx"}, {6'b0, tx_rdy}, {6'b0, etx});
  endtask

  task automatic wr(int c, logic [7:0] d, logic e, logic m);
    thr_wr = 0; thr_wr[c] = 1'b1; thr_wdata = d; efr_enh[c] = e; mcr_thr_en[c] = m;
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    // R1 reset state
    cs_n = 2'b10; rd_addr = 3'b111; mcr_rdy_en = 2'b11;
    #3;
    chk("R1 rx flags", {6'b0, rx_rdy}, 8'h00);
    chk("R1 tx flags", {6'b0, tx_rdy}, 8'h00);
    chk("R1 status", rd_data, 8'h00);
    @(negedge clk); rst_n = 1;

    // R4 coarse rx levels after reset (thr zero)
    fcr_rx_sel = 4'b0010; rxf[0] = 55; step("R4 coarse 56 below");
    rxf[0] = 56; step("R4 coarse 56 at");
    fcr_rx_sel = 4'b0011; rxf[0] = 59; step("R4 coarse 60 below");
    rxf[0] = 60; step("R4 coarse 60 at");
    // R5 coarse tx levels
    fcr_tx_sel = 4'b1000; txf[1] = 32; step("R5 coarse 32 at");
    txf[1] = 33; step("R5 coarse 32 below");
    fcr_tx_sel = 4'b0000; txf[1] = 56; step("R5 coarse 8 at");
    txf[1] = 57; step("R5 coarse 8 below");

    // R3 fine levels override coarse; R6 uses pre-write threshold in write cycle
    wr(0, 8'h31, 1, 1); rxf[0] = 12; step("R6 write cycle old level");
    rxf[0] = 11; step("R3 fine rx 12 below");
    rxf[0] = 12; step("R3 fine rx 12 at");
    txf[0] = 60; step("R3 fine tx 4 at");
    txf[0] = 61; step("R3 fine tx 4 below");
    // R10 channel B still on coarse
    rxf[1] = 12; fcr_rx_sel[3:2] = 2'b00; step("R10 B unaffected");

    // R2 dropped writes keep value
    wr(0, 8'hF0, 0, 1); step("R2 efr off");
    wr(0, 8'hF0, 1, 0); step("R2 mcr off");
    rxf[0] = 12; step("R2 kept level");
    chk("R2 kept level rx", {7'b0, rx_rdy[0]}, 8'h01);

    // R7 extremes, R6 full
    txf[0] = 0; rxf[0] = 64; step("R7 empty tx / R6 full rx");

    // R8 / R9 directed read path
    cs_n = 2'b10; rd_addr = 3'b111; mcr_rdy_en = 2'b01; loopback = 0; #1;
    chk("R8 status byte", rd_data, exp_rd());
    loopback = 2'b01; #1;
    chk("R9 loopback passes ord_a", rd_data, 8'hA5);
    cs_n = 2'b01; loopback = 0; #1;
    chk("R9 B without enable passes ord_b", rd_data, 8'h5A);
    cs_n = 2'b11; #1;
    chk("R9 no select", rd_data, 8'h00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      for (int c = 0; c < 2; c++) begin
        rxf[c] = $urandom_range(0, DEPTH);
        txf[c] = $urandom_range(0, DEPTH);
      end
      fcr_rx_sel = 4'($urandom); fcr_tx_sel = 4'($urandom);
      thr_wr = 2'($urandom); thr_wdata = 8'($urandom);
      efr_enh = ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom);
      mcr_thr_en = ($urandom_range(0, 3) != 0) ? 2'b11 : 2'($urandom);
      step("R6/R7 random");
      cs_n = 2'($urandom); rd_addr = ($urandom_range(0, 1) != 0) ? 3'b111 : 3'($urandom);
      mcr_rdy_en = 2'($urandom); loopback = 2'($urandom);
      ord_a = 8'($urandom); ord_b = 8'($urandom); #1;
      chk("R9 random read", rd_data, exp_rd());
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule